// File: doc/BRIEF.md
# Interrupt request intake with reset qualifier

This block sits in front of a processor's sequencer and decides, at each instruction boundary, whether an interrupt is taken and which vector type goes with it. There are two request sources. The maskable request is a level that is looked at only in the boundary cycle and only counts when the interrupt-enable flag is set. The non-maskable request pin passes through a synchronizer, and its rising edge sets a sticky pending bit that ignores the enable flag. That bit stays set until the interrupt is taken at a boundary.

When both sources are present at the same boundary, the non-maskable one wins and reports vector type 2. Otherwise the maskable request reports the type that the surrounding system supplies.

A raw active-high reset input is qualified by a run-length counter. The qualified reset output rises only after the raw reset has been seen high for a minimum number of consecutive clocks. While it is high, it blocks every take and discards any pending non-maskable request.

Top module: `irq_intake`

## Requirements
- R1: After power-on (`rst_ni` low) all outputs are 0. `sys_reset_o` goes high only once `raw_reset_i` has been sampled high on MIN_RST_CYC (default 4) consecutive rising clock edges, and it stays low for any shorter run.
- R2: `sys_reset_o` falls at the first rising edge at which `raw_reset_i` is sampled low.
- R3: While `sys_reset_o` is high, no interrupt is taken, and a non-maskable edge that arrives during that time is discarded.
- R4: A boundary cycle (`instr_end_i`=1) with `intr_req_i`=1, `int_enable_i`=1 and no pending non-maskable request produces `take_irq_o`=1 in the following cycle. In that cycle `irq_type_o` equals the `ext_type_i` value that was sampled at the boundary.
- R5: The maskable request has no effect when `int_enable_i`=0, and none outside a boundary cycle. It is not remembered from cycles before the boundary.
- R6: A rising edge on `nmi_pin_i` of at least one clock in width becomes pending after two synchronizer stages, whatever the state of `int_enable_i`. The pending bit remains set across cycles that are not boundaries. It is taken at the next boundary with `irq_type_o`=2, and taking it clears it.
- R7: Holding `nmi_pin_i` high produces only one take. No further take occurs until a new rising edge.
- R8: When a non-maskable request is pending and a maskable request is enabled at the same boundary, the non-maskable one is taken with type 2. A maskable request that is still present is taken at the next boundary.
- R9: `take_irq_o` is high only in the cycle directly after a boundary cycle. A single-cycle boundary strobe gives a pulse exactly one clock wide.
- R10: `irq_type_o` holds its last value in cycles without a take.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| raw_reset_i | input | 1 | Raw active-high reset request, to be qualified |
| intr_req_i | input | 1 | Maskable interrupt request level |
| int_enable_i | input | 1 | Interrupt-enable flag |
| nmi_pin_i | input | 1 | Asynchronous non-maskable request pin |
| instr_end_i | input | 1 | High in the last cycle of an instruction |
| ext_type_i | input | 8 | Vector type supplied for the maskable request |
| take_irq_o | output | 1 | One-cycle pulse: interrupt taken |
| irq_type_o | output | 8 | Vector type of the last taken interrupt |
| sys_reset_o | output | 1 | Qualified reset |

## Verification
All sixteen combinations of pending non-maskable request, boundary strobe, maskable request and enable flag are swept, each with a distinct external type. This separates masking from priority and from boundary gating, and a follow-up boundary shows whether the non-maskable request was cleared or stayed pending. The raw reset is driven high for runs of one to six clocks to locate the qualification threshold exactly. Further patterns cover a held-high non-maskable pin, a one-clock pulse on that pin, an edge that arrives entirely inside a qualified reset, and a boundary where both sources are present.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned IRQ_TYPE_W = 8;
  typedef logic [IRQ_TYPE_W-1:0] irq_type_t;
  localparam irq_type_t NMI_TYPE = irq_type_t'(2);
endpackage

// File: rtl/rst_qualifier.sv
module rst_qualifier #(
  parameter int unsigned MIN_RST_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_reset_i,
  output logic sys_reset_o
);
  localparam int unsigned CNT_W = $clog2(MIN_RST_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_RST_CYC);

  logic [CNT_W-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              run_q <= '0;
    else if (!raw_reset_i)    run_q <= '0;
    else if (run_q != CNT_MAX) run_q <= run_q + 1'b1;
  end

  assign sys_reset_o = (run_q == CNT_MAX);

  AST_QUAL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !raw_reset_i |=> !sys_reset_o); // R2
  AST_QUAL_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_reset_o) |-> $past(raw_reset_i)); // R1
endmodule

// File: rtl/nmi_edge_latch.sv
module nmi_edge_latch #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nmi_pin_i,
  input  logic flush_i,
  input  logic clear_i,
  output logic pend_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic prev_q, pend_q, rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], nmi_pin_i};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign rise = sync_q[SYNC_STAGES-1] & ~prev_q;

  // a fresh edge beats a same-cycle clear; reset flush beats both
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pend_q <= 1'b0;
    else if (flush_i) pend_q <= 1'b0;
    else              pend_q <= rise | (pend_q & ~clear_i);
  end

  assign pend_o = pend_q;

  AST_PEND_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && !clear_i && !flush_i |=> pend_q); // R6
  AST_PEND_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !pend_q); // R3
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      sys_reset_i,
  input  logic      instr_end_i,
  input  logic      intr_req_i,
  input  logic      int_enable_i,
  input  logic      nmi_pend_i,
  input  irq_type_t ext_type_i,
  output logic      nmi_clear_o,
  output logic      take_o,
  output irq_type_t type_o
);
  logic at_edge, grant_nmi, grant_mask;
  logic take_q;
  irq_type_t type_q;

  assign at_edge    = instr_end_i & ~sys_reset_i;
  assign grant_nmi  = at_edge & nmi_pend_i;
  assign grant_mask = at_edge & intr_req_i & int_enable_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      take_q <= 1'b0;
      type_q <= '0;
    end else begin
      take_q <= grant_nmi | grant_mask;
      if (grant_nmi)       type_q <= NMI_TYPE;
      else if (grant_mask) type_q <= ext_type_i;
    end
  end

  assign nmi_clear_o = grant_nmi;
  assign take_o      = take_q;
  assign type_o      = type_q;

  AST_NO_TAKE_IN_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_reset_i |=> !take_o); // R3
  AST_TAKE_AT_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !instr_end_i |=> !take_o); // R9
  AST_NMI_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_end_i && !sys_reset_i && nmi_pend_i |=> take_o && type_o == NMI_TYPE); // R8
  AST_MASK_TYPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_end_i && !sys_reset_i && !nmi_pend_i && intr_req_i && int_enable_i
    |=> take_o && type_o == $past(ext_type_i)); // R4
  AST_MASKED_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !nmi_pend_i && !int_enable_i |=> !take_o); // R5
  AST_TYPE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_o |-> $stable(type_o) || $past(!rst_ni)); // R10
endmodule

// File: rtl/irq_intake.sv
module irq_intake
  import irq_pkg::*;
#(
  parameter int unsigned MIN_RST_CYC = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  raw_reset_i,
  input  logic                  intr_req_i,
  input  logic                  int_enable_i,
  input  logic                  nmi_pin_i,
  input  logic                  instr_end_i,
  input  logic [IRQ_TYPE_W-1:0] ext_type_i,
  output logic                  take_irq_o,
  output logic [IRQ_TYPE_W-1:0] irq_type_o,
  output logic                  sys_reset_o
);
  logic sys_reset, nmi_pend, nmi_clear;

  rst_qualifier #(.MIN_RST_CYC(MIN_RST_CYC)) i_rst_qualifier (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .raw_reset_i (raw_reset_i),
    .sys_reset_o (sys_reset)
  );

  nmi_edge_latch #(.SYNC_STAGES(SYNC_STAGES)) i_nmi_edge_latch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .nmi_pin_i (nmi_pin_i),
    .flush_i   (sys_reset),
    .clear_i   (nmi_clear),
    .pend_o    (nmi_pend)
  );

  irq_arbiter i_irq_arbiter (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sys_reset_i  (sys_reset),
    .instr_end_i  (instr_end_i),
    .intr_req_i   (intr_req_i),
    .int_enable_i (int_enable_i),
    .nmi_pend_i   (nmi_pend),
    .ext_type_i   (ext_type_i),
    .nmi_clear_o  (nmi_clear),
    .take_o       (take_irq_o),
    .type_o       (irq_type_o)
  );

  assign sys_reset_o = sys_reset;

  AST_TAKE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!instr_end_i) |-> !take_irq_o || $past(rst_ni) == 1'b0 || 1'b1 == $past(instr_end_i)); // R9
endmodule

// File: tb/test_irq_intake.sv
module test_irq_intake;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic raw_reset_i = 0, intr_req_i = 0, int_enable_i = 0, nmi_pin_i = 0, instr_end_i = 0;
  logic [7:0] ext_type_i = 8'h00;
  logic take_irq_o, sys_reset_o;
  logic [7:0] irq_type_o;
  int n_chk = 0, n_fail = 0;
  logic [7:0] last_type = 8'h00;

  always #4 clk_i = ~clk_i;

  irq_intake i_irq_intake (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic nmi_edge();
    nmi_pin_i = 1'b1;
    tick(4);
  endtask

  task automatic nmi_low();
    nmi_pin_i = 1'b0;
    tick(4);
  endtask

  // one boundary cycle; result checked after the registering edge
  task automatic boundary(input logic req, input logic ie, input logic [7:0] t,
                          input logic exp_take, input logic [7:0] exp_type, input string tag);
    intr_req_i = req; int_enable_i = ie; ext_type_i = t; instr_end_i = 1'b1;
    tick();
    instr_end_i = 1'b0; intr_req_i = 1'b0;
    check({tag, " take"}, take_irq_o, exp_take);
    check({tag, " type"}, irq_type_o, exp_type);
    if (exp_take) last_type = exp_type;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    tick(2);
    check("R1 reset take", take_irq_o, 0);
    check("R1 reset type", irq_type_o, 0);
    check("R1 reset sys", sys_reset_o, 0);
    rst_ni = 1'b1;
    tick(2);

    // R1/R2: threshold sweep over run lengths
    for (int w = 1; w <= 6; w++) begin
      raw_reset_i = 1'b1;
      for (int k = 1; k <= w; k++) begin
        tick();
        check($sformatf("R1 run %0d at %0d", w, k), sys_reset_o, (k >= 4));
      end
      raw_reset_i = 1'b0;
      tick();
      check($sformatf("R2 drop after %0d", w), sys_reset_o, 0);
      tick();
    end

    // R3: edge and requests inside a qualified reset are discarded
    raw_reset_i = 1'b1;
    tick(4);
    nmi_pin_i = 1'b1;
    intr_req_i = 1'b1; int_enable_i = 1'b1; instr_end_i = 1'b1;
    for (int k = 0; k < 6; k++) begin
      tick();
      check("R3 no take in reset", take_irq_o, 0);
    end
    instr_end_i = 1'b0; intr_req_i = 1'b0;
    raw_reset_i = 1'b0;
    tick(2);
    boundary(1'b0, 1'b0, 8'h11, 1'b0, last_type, "R3 edge discarded");
    nmi_low();

    // R4/R5/R6/R8: sweep {nmi, end, req, ie}
    for (int c = 0; c < 16; c++) begin
      logic nmi, en, rq, ie, exp_take;
      logic [7:0] t, exp_type;
      nmi = c[3]; en = c[2]; rq = c[1]; ie = c[0];
      t = 8'h40 + 8'(c);
      if (nmi) nmi_edge();
      exp_take = en & (nmi | (rq & ie));
      exp_type = exp_take ? (nmi ? 8'd2 : t) : last_type;
      intr_req_i = rq; int_enable_i = ie; ext_type_i = t; instr_end_i = en;
      tick();
      instr_end_i = 1'b0; intr_req_i = 1'b0;
      check($sformatf("R4 R5 R8 combo %0d take", c), take_irq_o, exp_take);
      check($sformatf("R4 R5 R8 combo %0d type", c), irq_type_o, exp_type);
      if (exp_take) last_type = exp_type;
      tick();
      check($sformatf("R9 combo %0d pulse end", c), take_irq_o, 0);
      if (nmi) begin
        nmi_low();
        // pending survives non-boundary cycles, cleared once taken
        boundary(1'b0, 1'b0, 8'h22, !en, !en ? 8'd2 : last_type, "R6 pending after combo");
        tick();
      end
    end

    // R5: request raised then dropped before the boundary is not remembered
    intr_req_i = 1'b1; int_enable_i = 1'b1; tick(3);
    intr_req_i = 1'b0; tick();
    boundary(1'b0, 1'b1, 8'h33, 1'b0, last_type, "R5 no memory");

    // R7: held-high pin gives a single take
    nmi_edge();
    boundary(1'b0, 1'b0, 8'h44, 1'b1, 8'd2, "R7 first");
    tick(3);
    boundary(1'b0, 1'b0, 8'h45, 1'b0, 8'd2, "R7 no retrigger");
    nmi_low();

    // R6: one-clock pin pulse is caught
    nmi_pin_i = 1'b1; tick(); nmi_pin_i = 1'b0; tick(4);
    boundary(1'b0, 1'b0, 8'h55, 1'b1, 8'd2, "R6 short pulse");

    // R8: both at once, maskable follows at next boundary
    nmi_edge();
    boundary(1'b1, 1'b1, 8'h66, 1'b1, 8'd2, "R8 nmi first");
    boundary(1'b1, 1'b1, 8'h67, 1'b1, 8'h67, "R8 maskable next");
    nmi_low();

    // R9/R10: single strobe with request still high, type holds
    intr_req_i = 1'b1; int_enable_i = 1'b1; ext_type_i = 8'h77; instr_end_i = 1'b1;
    tick();
    instr_end_i = 1'b0; ext_type_i = 8'h99;
    check("R9 pulse high", take_irq_o, 1);
    tick();
    check("R9 pulse one clock", take_irq_o, 0);
    check("R10 type holds", irq_type_o, 8'h77);
    intr_req_i = 1'b0;
    tick(2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule